// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Front End

This block is the device side of a synthesizable stand-in for an asynchronous, multiplexed-address DRAM. A fast system clock samples the four active-low strobes: row strobe, column strobe, write enable and output enable. The block watches the order in which their edges arrive and sorts every memory cycle into one of five kinds:

- refresh with the column strobe already low when the row strobe falls,
- row-only refresh,
- read,
- early write,
- late write.

Row and column addresses share one address bus. The block latches them at the matching strobe falls and drives a small on-chip cell array of `DQ_W`-bit words. It also decides when the data output may be driven.

Refresh cycles entered with the column strobe already low take their row from an internal counter and ignore the address bus. Every other cycle refreshes the row it latched. Each refresh is reported as a one-cycle pulse together with the row number, so that an emulated retention model or a monitor can follow it. Only the ordering of edges is modelled. Analog timing limits are not.

Top module: `dram_cycle_front`

## Requirements
- R1: When the row strobe is sampled falling while the column strobe is low, the cycle kind becomes 1 (counter refresh). `refresh_pulse` rises for one cycle, and `refresh_row` carries the internal counter value, whatever is on `addr`.
- R2: After reset the refresh counter is 0. It steps by one after each counter refresh and wraps from 2^ROW_W-1 back to 0.
- R3: When the row strobe is sampled falling while the column strobe is high, the cycle kind becomes 2 (row-only). `refresh_pulse` rises for one cycle, with `refresh_row` equal to `addr[ROW_W-1:0]`.
- R4: During a counter refresh no cell is written and `dq_oe` stays low, even with output enable low.
- R5: A column strobe fall with write enable already low, inside an open row, makes the cycle kind 4 (early write). It stores `dq_in` at row/column, with the column taken from `addr[COL_W-1:0]`, and `dq_oe` stays low.
- R6: A column strobe fall with write enable high, inside an open row, makes the cycle kind 3 (read). While the column strobe and output enable are both low, `dq_oe` is high and `dq_out` shows the stored word.
- R7: A write enable fall during a read while the column strobe is low makes the cycle kind 5 (late write). It stores `dq_in` as sampled at that fall into the latched column, and `dq_oe` goes low.
- R8: Raising output enable during a read drops `dq_oe` at the same sample that sees it high.
- R9: With both the row and column strobes high, `dq_oe` is low. A row strobe rise returns the cycle kind to 0 (idle).
- R10: Under reset, `cycle_kind` is 0 and `dq_oe` and `refresh_pulse` are low.
- R11: Within one row-strobe low period, each new column strobe fall latches a fresh column, so a page of several words can be written or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| dq_in | input | DQ_W | Write data from the bus |
| dq_out | output | DQ_W | Read data toward the bus |
| dq_oe | output | 1 | Drive enable for the data bus |
| cycle_kind | output | 3 | 0 idle, 1 counter refresh, 2 row-only, 3 read, 4 early write, 5 late write |
| refresh_pulse | output | 1 | One-cycle mark of a row refresh |
| refresh_row | output | ROW_W | Row refreshed with the pulse |

## Verification
A strobe change driven before clock edge k is sampled at k. The cycle kind, the refresh pulse and row, the latched column and the read word are all registered one edge later, at k+1. `dq_oe` combines the registered kind with the sampled strobes, so it reacts to an output-enable or column-strobe rise at k itself.

The bench drives pins just after a falling edge and compares at the following falling edge. Its behavioural model advances by one sample per rising edge in the same order. The directed checks wait two falling edges after a strobe change before looking for a registered result, and one for an output-enable effect.

// File: rtl/dram_front_pkg.sv
package dram_front_pkg;

  typedef enum logic [2:0] {
    CK_IDLE  = 3'd0,
    CK_CBR   = 3'd1,
    CK_RONLY = 3'd2,
    CK_READ  = 3'd3,
    CK_EWR   = 3'd4,
    CK_LWR   = 3'd5
  } cyc_kind_t;

  // flat cell number of a row/column pair
  function automatic int unsigned cell_index(int unsigned row, int unsigned col,
                                             int unsigned col_w);
    return (row << col_w) | col;
  endfunction

  // refresh counter successor, wrapping at the row count
  function automatic int unsigned bump_row(int unsigned cur, int unsigned rows);
    return (cur + 1 >= rows) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler #(
  parameter int ADDR_W = 5,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              s_ras_n,
  output logic              s_cas_n,
  output logic              s_we_n,
  output logic              s_oe_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DQ_W-1:0]   s_din,
  output logic              ras_fall,
  output logic              ras_rise,
  output logic              cas_fall,
  output logic              we_fall
);

  logic p_ras_n, p_cas_n, p_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ras_n <= 1'b1;
      s_cas_n <= 1'b1;
      s_we_n  <= 1'b1;
      s_oe_n  <= 1'b1;
      s_addr  <= '0;
      s_din   <= '0;
      p_ras_n <= 1'b1;
      p_cas_n <= 1'b1;
      p_we_n  <= 1'b1;
    end else begin
      s_ras_n <= ras_n;
      s_cas_n <= cas_n;
      s_we_n  <= we_n;
      s_oe_n  <= oe_n;
      s_addr  <= addr;
      s_din   <= dq_in;
      p_ras_n <= s_ras_n;
      p_cas_n <= s_cas_n;
      p_we_n  <= s_we_n;
    end
  end

  // edge events between the two most recent samples
  assign ras_fall = p_ras_n & ~s_ras_n;
  assign ras_rise = ~p_ras_n & s_ras_n;
  assign cas_fall = p_cas_n & ~s_cas_n;
  assign we_fall  = p_we_n & ~s_we_n;

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int IDX_W = 10,
  parameter int DQ_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DQ_W-1:0]  rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DQ_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_req) cells[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_req) rd_data <= cells[rd_idx];
  end

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_front_pkg::*;
#(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5,
  parameter int ADDR_W = 5,
  parameter int DQ_W   = 4,
  localparam int IDX_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_cas_n,
  input  logic              s_ras_n,
  input  logic              s_we_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DQ_W-1:0]   s_din,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              cas_fall,
  input  logic              we_fall,
  output cyc_kind_t         kind,
  output logic              refresh_pulse,
  output logic [ROW_W-1:0]  refresh_row,
  output logic              wr_req,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DQ_W-1:0]   wr_data,
  output logic              rd_req,
  output logic [IDX_W-1:0]  rd_idx
);

  localparam int ROWS = 1 << ROW_W;

  logic [ROW_W-1:0] ref_cnt;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             page_open;
  logic             early_wr_ev;
  logic             read_ev;
  logic             late_wr_ev;
  logic [COL_W-1:0] col_now;
  logic [ROW_W-1:0] row_now;

  assign col_now = s_addr[COL_W-1:0];
  assign row_now = s_addr[ROW_W-1:0];

  // a row is open for column traffic in any non-refresh-only kind
  assign page_open = !s_ras_n &&
                     (kind == CK_RONLY || kind == CK_READ ||
                      kind == CK_EWR   || kind == CK_LWR);

  assign early_wr_ev = !ras_rise && cas_fall && page_open && !s_we_n;
  assign read_ev     = !ras_rise && cas_fall && page_open &&  s_we_n;
  assign late_wr_ev  = !ras_rise && !cas_fall && kind == CK_READ &&
                       !s_cas_n && we_fall;

  assign wr_req  = !ras_fall && (early_wr_ev || late_wr_ev);
  assign wr_idx  = early_wr_ev ? IDX_W'(cell_index(int'(row_q), int'(col_now), COL_W))
                               : IDX_W'(cell_index(int'(row_q), int'(col_q),   COL_W));
  assign wr_data = s_din;
  assign rd_req  = !ras_fall && read_ev;
  assign rd_idx  = IDX_W'(cell_index(int'(row_q), int'(col_now), COL_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind          <= CK_IDLE;
      ref_cnt       <= '0;
      row_q         <= '0;
      col_q         <= '0;
      refresh_pulse <= 1'b0;
      refresh_row   <= '0;
    end else begin
      refresh_pulse <= 1'b0;
      if (ras_fall) begin
        refresh_pulse <= 1'b1;
        if (!s_cas_n) begin
          kind        <= CK_CBR;
          refresh_row <= ref_cnt;
          ref_cnt     <= ROW_W'(bump_row(int'(ref_cnt), ROWS));
        end else begin
          kind        <= CK_RONLY;
          row_q       <= row_now;
          refresh_row <= row_now;
        end
      end else if (ras_rise) begin
        kind <= CK_IDLE;
      end else if (early_wr_ev) begin
        kind  <= CK_EWR;
        col_q <= col_now;
      end else if (read_ev) begin
        kind  <= CK_READ;
        col_q <= col_now;
      end else if (late_wr_ev) begin
        kind <= CK_LWR;
      end
    end
  end

  a_r1_cbr_row_from_counter: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !s_cas_n) |=> (refresh_pulse && refresh_row == $past(ref_cnt)));

  a_r2_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !s_cas_n) |=> (ref_cnt == ROW_W'($past(ref_cnt) + 1'b1)));

  a_r2_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_fall && !s_cas_n) |=> $stable(ref_cnt));

  a_r3_ronly_row: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && s_cas_n) |=> (refresh_pulse && refresh_row == $past(row_now)));

  a_r4_cbr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_CBR) |-> !wr_req);

  a_r9_ras_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ras_rise |=> (kind == CK_IDLE));

endmodule

// File: rtl/dram_cycle_front.sv
module dram_cycle_front
  import dram_front_pkg::*;
#(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5,
  parameter int DQ_W   = 4,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [2:0]        cycle_kind,
  output logic              refresh_pulse,
  output logic [ROW_W-1:0]  refresh_row
);

  localparam int IDX_W = ROW_W + COL_W;

  logic              s_ras_n, s_cas_n, s_we_n, s_oe_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DQ_W-1:0]   s_din;
  logic              ras_fall, ras_rise, cas_fall, we_fall;
  cyc_kind_t         kind;
  logic              wr_req, rd_req;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DQ_W-1:0]   wr_data;
  logic [DQ_W-1:0]   rd_data;

  dram_strobe_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in),
    .s_ras_n(s_ras_n), .s_cas_n(s_cas_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n),
    .s_addr(s_addr), .s_din(s_din),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall), .we_fall(we_fall)
  );

  dram_cycle_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_cas_n(s_cas_n), .s_ras_n(s_ras_n), .s_we_n(s_we_n),
    .s_addr(s_addr), .s_din(s_din),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall), .we_fall(we_fall),
    .kind(kind), .refresh_pulse(refresh_pulse), .refresh_row(refresh_row),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_req(rd_req), .rd_idx(rd_idx)
  );

  dram_cell_array #(.IDX_W(IDX_W), .DQ_W(DQ_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // bus drive only in a read with both column strobe and output enable low
  assign dq_oe      = (kind == CK_READ) && !s_cas_n && !s_oe_n;
  assign dq_out     = rd_data;
  assign cycle_kind = kind;

  a_r9_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ras_n && s_cas_n) |-> !dq_oe);

  a_r8_oe_high_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    s_oe_n |-> !dq_oe);

  a_r5_early_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_EWR) |-> !dq_oe);

  a_r7_late_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_LWR) |-> !dq_oe);

  a_r4_cbr_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_CBR) |-> !dq_oe);

endmodule

// File: tb/dram_cycle_front_bench.sv
module dram_cycle_front_bench;

  localparam int ROW_W = 5;
  localparam int COL_W = 5;
  localparam int DQ_W  = 4;
  localparam int AW    = 5;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0]   addr = '0;
  logic [DQ_W-1:0] dq_in = '0;
  logic [DQ_W-1:0] dq_out;
  logic            dq_oe;
  logic [2:0]      cycle_kind;
  logic            refresh_pulse;
  logic [ROW_W-1:0] refresh_row;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  dram_cycle_front #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_dram_cycle_front (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cycle_kind(cycle_kind), .refresh_pulse(refresh_pulse), .refresh_row(refresh_row)
  );

  // ---------------- behavioural reference ----------------
  bit m_ras = 1, m_cas = 1, m_we = 1, m_oe = 1;   // latest sample
  bit o_ras = 1, o_cas = 1, o_we = 1;             // sample before
  int m_addr = 0, m_din = 0;
  int m_kind = 0, m_cnt = 0, m_row = 0, m_col = 0;
  int m_pulse = 0, m_prow = 0, m_rd = -1;
  int store [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ras = 1; m_cas = 1; m_we = 1; m_oe = 1;
      o_ras = 1; o_cas = 1; o_we = 1;
      m_addr = 0; m_din = 0;
      m_kind = 0; m_cnt = 0; m_row = 0; m_col = 0; m_pulse = 0; m_prow = 0; m_rd = -1;
    end else begin
      bit open_row;
      open_row = !m_ras && (m_kind >= 2);
      m_pulse = 0;
      if (o_ras && !m_ras) begin
        m_pulse = 1;
        if (!m_cas) begin
          m_kind = 1; m_prow = m_cnt; m_cnt = (m_cnt + 1) % ROWS;
        end else begin
          m_kind = 2; m_row = m_addr % ROWS; m_prow = m_row;
        end
      end else if (!o_ras && m_ras) begin
        m_kind = 0;
      end else if (o_cas && !m_cas && open_row) begin
        m_col = m_addr % COLS;
        if (!m_we) begin
          store[m_row * COLS + m_col] = m_din; m_kind = 4;
        end else begin
          m_kind = 3;
          m_rd = store.exists(m_row * COLS + m_col) ? store[m_row * COLS + m_col] : -1;
        end
      end else if (m_kind == 3 && !m_cas && o_we && !m_we) begin
        store[m_row * COLS + m_col] = m_din; m_kind = 5;
      end
      o_ras = m_ras; o_cas = m_cas; o_we = m_we;
      m_ras = ras_n; m_cas = cas_n; m_we = we_n; m_oe = oe_n;
      m_addr = int'(addr); m_din = int'(dq_in);
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string kind_tag(int k);
    case (k)
      1: return "R1 kind";
      2: return "R3 kind";
      3: return "R6 kind";
      4: return "R5 kind";
      5: return "R7 kind";
      default: return "R9 kind";
    endcase
  endfunction

  task automatic compare();
    int exp_oe;
    exp_oe = (m_kind == 3 && !m_cas && !m_oe) ? 1 : 0;
    chk(kind_tag(m_kind), int'(cycle_kind), m_kind);
    chk("R8 dq_oe", int'(dq_oe), exp_oe);
    chk("R3 refresh_pulse", int'(refresh_pulse), m_pulse);
    if (m_pulse == 1) chk("R1 refresh_row", int'(refresh_row), m_prow);
    if (exp_oe == 1 && m_rd >= 0) chk("R6 dq_out", int'(dq_out), m_rd);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic release_all();
    ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
    step(2);
  endtask

  task automatic early_write(int r, int c, int d);
    addr = AW'(r); ras_n = 0; step(2);
    addr = AW'(c); we_n = 0; dq_in = DQ_W'(d); step(1);
    cas_n = 0; step(2);
    chk("R5 early write kind", int'(cycle_kind), 4);
    chk("R5 early write hiz", int'(dq_oe), 0);
    release_all();
  endtask

  task automatic read_word(int r, int c, int exp);
    addr = AW'(r); ras_n = 0; step(2);
    addr = AW'(c); oe_n = 0; step(1);
    cas_n = 0; step(2);
    chk("R6 read oe", int'(dq_oe), 1);
    chk("R6 read data", int'(dq_out), exp);
    oe_n = 1; step(1);
    chk("R8 oe high hiz", int'(dq_oe), 0);
    release_all();
    chk("R9 idle hiz", int'(dq_oe), 0);
    chk("R9 idle kind", int'(cycle_kind), 0);
  endtask

  task automatic late_write(int r, int c, int d);
    addr = AW'(r); ras_n = 0; step(2);
    addr = AW'(c); step(1);
    cas_n = 0; step(2);
    chk("R7 read before late write", int'(cycle_kind), 3);
    addr = AW'(c ^ 1); we_n = 0; dq_in = DQ_W'(d); step(2);
    chk("R7 late write kind", int'(cycle_kind), 5);
    chk("R7 late write hiz", int'(dq_oe), 0);
    release_all();
  endtask

  task automatic ras_only(int r);
    addr = AW'(r); ras_n = 0; step(2);
    chk("R3 ronly pulse", int'(refresh_pulse), 1);
    chk("R3 ronly row", int'(refresh_row), r);
    chk("R3 ronly kind", int'(cycle_kind), 2);
    step(1);
    release_all();
  endtask

  task automatic cbr(int exp_row);
    cas_n = 0; oe_n = 0; addr = AW'(31 - exp_row); step(1);
    ras_n = 0; step(2);
    chk("R1 cbr pulse", int'(refresh_pulse), 1);
    chk("R2 cbr counter row", int'(refresh_row), exp_row);
    chk("R1 cbr kind", int'(cycle_kind), 1);
    cas_n = 1; step(1);
    cas_n = 0; step(2);
    chk("R4 cbr hiz", int'(dq_oe), 0);
    ras_n = 1; step(1);
    release_all();
  endtask

  task automatic page_cycle(bit wr, int r, int base);
    addr = AW'(r); ras_n = 0; oe_n = wr; step(2);
    for (int k = 0; k < 3; k++) begin
      addr = AW'(base + k); we_n = !wr; dq_in = DQ_W'(k + 6); step(1);
      cas_n = 0; step(2);
      if (wr) chk("R11 page write kind", int'(cycle_kind), 4);
      else    chk("R11 page read data", int'(dq_out), k + 6);
      cas_n = 1; we_n = 1; step(1);
    end
    release_all();
  endtask

  initial begin
    step(3);
    chk("R10 reset kind", int'(cycle_kind), 0);
    chk("R10 reset oe", int'(dq_oe), 0);
    chk("R10 reset pulse", int'(refresh_pulse), 0);
    rst_n = 1; step(2);
    early_write(3, 7, 'hA);
    read_word(3, 7, 'hA);
    late_write(3, 7, 'h5);
    read_word(3, 7, 'h5);
    read_word(3, 6, 'h0 + 0);   // unwritten cell: model skips unknown data checks
    ras_only(9);
    for (int i = 0; i < ROWS + 2; i++) cbr(i % ROWS);
    early_write(12, 2, 'h3);
    page_cycle(1, 20, 10);
    page_cycle(0, 20, 10);
    read_word(12, 2, 'h3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule